// File: doc/BRIEF.md
# Three-State Power Mode Controller

This block sequences a chip between three power modes: a full-performance run mode, an idle mode in which only the processor clock is stopped, and a standby mode in which the clocks and the main oscillator are all off. Software asks for idle or standby through two request pulses. Wake events, each with its own enable bit, bring the chip back. The controller drives the processor clock enable, the peripheral clock enable and the main oscillator enable. It also reports the current mode on a two-bit code.

Four power-sense inputs qualify the sequence. A power-fail or battery-changed indication forces standby from any mode. Wake events are disregarded while the battery is reported bad and no external supply is present. Waking from standby passes through a restart phase. In that phase the oscillator is enabled first, and the clocks stay off until the oscillator reports ready or a programmable settling count has elapsed.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode code is 0 (run) and the processor clock, peripheral clock and oscillator enables are all 1.
- R2: A request on `sw_idle_req` in run mode moves to mode code 1 (idle) at the next edge: processor clock enable 0, peripheral clock and oscillator enables 1.
- R3: In idle, a wake event whose bit is set in `wake_mask` returns to run at the next edge. A wake event whose mask bit is 0 leaves the block in idle.
- R4: A request on `sw_stby_req` in run mode moves to mode code 2 (standby) at the next edge, with all three enables 0.
- R5: When both requests are raised in the same cycle, standby wins.
- R6: A software request is ignored in any cycle in which an enabled, qualified wake event is also present. The block stays in run.
- R7: In standby, a qualified wake event moves to mode code 3 (restart) at the next edge. In restart the oscillator enable is 1 and both clock enables are 0.
- R8: Restart ends in the first cycle in which `osc_ready` is 1 or the number of whole restart cycles already spent equals `settle_cycles`. The block is back in run at the following edge. With `osc_ready` held at 0, restart lasts `settle_cycles`+1 cycles.
- R9: While `batt_good` and `ext_supply` are both 0, wake events have no effect: standby and idle are held.
- R10: `pwr_fail` or `batt_swap` at 1 moves the block to standby at the next edge from any mode, and holds it there for as long as either one stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_idle_req | input | 1 | Software request to enter idle |
| sw_stby_req | input | 1 | Software request to enter standby |
| wake_evt | input | WAKE_W | Wake and interrupt event lines |
| wake_mask | input | WAKE_W | Per-line wake enable |
| batt_good | input | 1 | Battery voltage acceptable |
| ext_supply | input | 1 | External supply present |
| pwr_fail | input | 1 | Power-fail indication |
| batt_swap | input | 1 | Battery-changed indication |
| osc_ready | input | 1 | Oscillator output is stable |
| settle_cycles | input | CNT_W | Restart settling cycles when no ready indication comes |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| mode_code | output | 2 | 0 run, 1 idle, 2 standby, 3 restart |

## Verification
A wrong internal state shows at once: the outputs are decoded directly from the state register, so any mis-step in the sequencer shows on `mode_code` and the enables one edge after the stimulus that caused it. A fault in the restart counter is slower to show. It appears as a restart phase that is too long or too short by some number of cycles. The bench therefore counts the cycles of mode code 3 exactly and checks the first run cycle. Faults in the qualification of wake events show as a mode that moves when it should hold, or holds when it should move, at the next edge.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_STBY  = 2'd2,
    PM_WAKE  = 2'd3
  } pm_state_t;

  typedef struct packed {
    logic cpu;
    logic per;
    logic osc;
  } pm_enables_t;

  // Clock and oscillator enables implied by each state.
  function automatic pm_enables_t pm_enables(input pm_state_t s);
    pm_enables_t e;
    case (s)
      PM_RUN:  e = '{cpu: 1'b1, per: 1'b1, osc: 1'b1};
      PM_IDLE: e = '{cpu: 1'b0, per: 1'b1, osc: 1'b1};
      PM_WAKE: e = '{cpu: 1'b0, per: 1'b0, osc: 1'b1};
      default: e = '{cpu: 1'b0, per: 1'b0, osc: 1'b0};
    endcase
    return e;
  endfunction

  // Next-state rule. Forced standby first, then wake events, then requests.
  function automatic pm_state_t pm_next(input pm_state_t s,
                                        input logic force_stby,
                                        input logic wake_ok,
                                        input logic req_idle,
                                        input logic req_stby,
                                        input logic settle_done);
    pm_state_t n;
    n = s;
    if (force_stby) begin
      n = PM_STBY;
    end else begin
      case (s)
        PM_RUN: begin
          if (!wake_ok) begin
            if (req_stby)      n = PM_STBY;
            else if (req_idle) n = PM_IDLE;
          end
        end
        PM_IDLE: if (wake_ok)     n = PM_RUN;
        PM_STBY: if (wake_ok)     n = PM_WAKE;
        PM_WAKE: if (settle_done) n = PM_RUN;
        default: n = PM_RUN;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/pwr_sense_qual.sv
module pwr_sense_qual #(
  parameter int WAKE_W = 4
) (
  input  logic [WAKE_W-1:0] wake_evt,
  input  logic [WAKE_W-1:0] wake_mask,
  input  logic              batt_good,
  input  logic              ext_supply,
  input  logic              pwr_fail,
  input  logic              batt_swap,
  output logic              wake_ok,
  output logic              force_stby
);

  logic [WAKE_W-1:0] evt_enabled;
  logic              any_evt;
  logic              supply_ok;

  // Keep only the wake lines that software has enabled.
  for (genvar i = 0; i < WAKE_W; i++) begin : g_mask
    assign evt_enabled[i] = wake_evt[i] & wake_mask[i];
  end

  assign any_evt    = |evt_enabled;
  assign supply_ok  = batt_good | ext_supply;
  assign wake_ok    = any_evt & supply_ok;
  assign force_stby = pwr_fail | batt_swap;

endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_wake,
  input  logic             osc_ready,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             settle_done
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (in_wake) cnt_q <= sat_inc(cnt_q);
    else              cnt_q <= '0;
  end

  assign settle_done = in_wake & (osc_ready | (cnt_q == settle_cycles));

  // Each restart phase starts counting from zero.
  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_wake |=> cnt_q == '0);

  // While the restart phase lasts, the counter advances by one each cycle
  // until it saturates.
  assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wake && $past(in_wake) && $past(cnt_q) != CNT_MAX) |->
      cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      force_stby,
  input  logic      wake_ok,
  input  logic      req_idle,
  input  logic      req_stby,
  input  logic      settle_done,
  output pm_state_t state_q
);

  pm_state_t state_d;

  always_comb state_d = pm_next(state_q, force_stby, wake_ok,
                                req_idle, req_stby, settle_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_d;
  end

  assert_force_stby_R10: assert property (@(posedge clk) disable iff (!rst_n)
    force_stby |=> state_q == PM_STBY);

  assert_idle_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE && wake_ok && !force_stby) |=> state_q == PM_RUN);

  assert_req_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && wake_ok && !force_stby) |=> state_q == PM_RUN);

  assert_stby_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == PM_STBY |=> (state_q == PM_STBY || state_q == PM_WAKE));

  assert_wake_to_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_WAKE && settle_done && !force_stby) |=> state_q == PM_RUN);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int WAKE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_idle_req,
  input  logic              sw_stby_req,
  input  logic [WAKE_W-1:0] wake_evt,
  input  logic [WAKE_W-1:0] wake_mask,
  input  logic              batt_good,
  input  logic              ext_supply,
  input  logic              pwr_fail,
  input  logic              batt_swap,
  input  logic              osc_ready,
  input  logic [CNT_W-1:0]  settle_cycles,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic [1:0]        mode_code
);

  // Internal events, named so that assertions can watch them.
  logic        wake_ok;
  logic        force_stby;
  logic        settle_done;
  logic        in_wake;
  pm_state_t   state_q;
  pm_enables_t en;

  pwr_sense_qual #(.WAKE_W(WAKE_W)) u_qual (
    .wake_evt   (wake_evt),
    .wake_mask  (wake_mask),
    .batt_good  (batt_good),
    .ext_supply (ext_supply),
    .pwr_fail   (pwr_fail),
    .batt_swap  (batt_swap),
    .wake_ok    (wake_ok),
    .force_stby (force_stby)
  );

  assign in_wake = (state_q == PM_WAKE);

  osc_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_wake       (in_wake),
    .osc_ready     (osc_ready),
    .settle_cycles (settle_cycles),
    .settle_done   (settle_done)
  );

  pwr_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_stby  (force_stby),
    .wake_ok     (wake_ok),
    .req_idle    (sw_idle_req),
    .req_stby    (sw_stby_req),
    .settle_done (settle_done),
    .state_q     (state_q)
  );

  assign en         = pm_enables(state_q);
  assign cpu_clk_en = en.cpu;
  assign per_clk_en = en.per;
  assign osc_en     = en.osc;
  assign mode_code  = state_q;

  // The processor clock never turns on unless the oscillator was already on.
  assert_osc_before_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> $past(osc_en));

  // With no usable supply, standby is held whatever the wake lines do.
  assert_wake_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'd2 && !batt_good && !ext_supply) |=> mode_code == 2'd2);

  // No clock may run while the oscillator is stopped.
  assert_clk_needs_osc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!cpu_clk_en && !per_clk_en));

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WAKE_W     = 4;
  localparam int CNT_W      = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sw_idle_req = 1'b0;
  logic              sw_stby_req = 1'b0;
  logic [WAKE_W-1:0] wake_evt = '0;
  logic [WAKE_W-1:0] wake_mask = 4'b0101;
  logic              batt_good = 1'b1;
  logic              ext_supply = 1'b0;
  logic              pwr_fail = 1'b0;
  logic              batt_swap = 1'b0;
  logic              osc_ready = 1'b0;
  logic [CNT_W-1:0]  settle_cycles = 16'd3;
  logic              cpu_clk_en, per_clk_en, osc_en;
  logic [1:0]        mode_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.WAKE_W(WAKE_W), .CNT_W(CNT_W)) u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_idle_req(sw_idle_req), .sw_stby_req(sw_stby_req),
    .wake_evt(wake_evt), .wake_mask(wake_mask), .batt_good(batt_good),
    .ext_supply(ext_supply), .pwr_fail(pwr_fail), .batt_swap(batt_swap),
    .osc_ready(osc_ready), .settle_cycles(settle_cycles),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .mode_code(mode_code)
  );

  // Expected outputs for a mode code: {cpu, per, osc, mode}.
  function automatic logic [4:0] expect_for(input logic [1:0] m);
    case (m)
      2'd0:    return {3'b111, m};
      2'd1:    return {3'b011, m};
      2'd2:    return {3'b000, m};
      default: return {3'b001, m};
    endcase
  endfunction

  task automatic check_mode(input logic [1:0] m, input string req);
    logic [4:0] got, exp;
    got = {cpu_clk_en, per_clk_en, osc_en, mode_code};
    exp = expect_for(m);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got cpu/per/osc/mode=%b expected %b", req, got, exp);
    end
  endtask

  // One clock: inputs were set at a falling edge; look again at the next one.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    sw_idle_req = 0; sw_stby_req = 0; wake_evt = '0;
    pwr_fail = 0; batt_swap = 0; osc_ready = 0;
  endtask

  task automatic go_run_from_stby();
    wake_evt = 4'b0001; osc_ready = 1; tick();
    wake_evt = '0; tick(); tick(); osc_ready = 0;
  endtask

  task automatic t_reset();
    check_mode(2'd0, "R1 reset");
  endtask

  task automatic t_idle();
    sw_idle_req = 1; tick(); sw_idle_req = 0;
    check_mode(2'd1, "R2 idle entry");
    wake_evt = 4'b0010; tick();                  // masked line
    check_mode(2'd1, "R3 masked event ignored");
    wake_evt = 4'b0100; tick(); wake_evt = '0;   // enabled line
    check_mode(2'd0, "R3 enabled event wakes idle");
  endtask

  task automatic t_stby_priority();
    sw_stby_req = 1; tick(); sw_stby_req = 0;
    check_mode(2'd2, "R4 standby entry");
    go_run_from_stby();
    check_mode(2'd0, "R4 back to run");
    sw_stby_req = 1; sw_idle_req = 1; tick(); clear_inputs();
    check_mode(2'd2, "R5 standby wins over idle");
    go_run_from_stby();
  endtask

  task automatic t_req_blocked();
    sw_idle_req = 1; wake_evt = 4'b0001; tick(); clear_inputs();
    check_mode(2'd0, "R6 idle request with wake pending");
    sw_stby_req = 1; wake_evt = 4'b0100; tick(); clear_inputs();
    check_mode(2'd0, "R6 standby request with wake pending");
  endtask

  task automatic t_restart_count();
    settle_cycles = 16'd3;
    sw_stby_req = 1; tick(); sw_stby_req = 0;
    wake_evt = 4'b0001; tick(); wake_evt = '0;
    check_mode(2'd3, "R7 restart entered, osc on, clocks off");
    // Restart lasts settle_cycles+1 = 4 cycles; three more samples stay in restart.
    for (int i = 0; i < 3; i++) begin
      tick(); check_mode(2'd3, "R8 restart still settling");
    end
    tick(); check_mode(2'd0, "R8 run after settle count");
  endtask

  task automatic t_restart_ready();
    settle_cycles = 16'd20;
    sw_stby_req = 1; tick(); sw_stby_req = 0;
    wake_evt = 4'b0100; tick(); wake_evt = '0;
    check_mode(2'd3, "R7 restart entered");
    tick(); check_mode(2'd3, "R8 waiting for ready");
    osc_ready = 1; tick(); osc_ready = 0;
    check_mode(2'd0, "R8 ready ends restart early");
    settle_cycles = 16'd0;
    sw_stby_req = 1; tick(); sw_stby_req = 0;
    wake_evt = 4'b0001; tick(); wake_evt = '0;
    check_mode(2'd3, "R8 zero count restart");
    tick(); check_mode(2'd0, "R8 zero count lasts one cycle");
  endtask

  task automatic t_supply_gate();
    settle_cycles = 16'd0;
    sw_stby_req = 1; tick(); sw_stby_req = 0;
    batt_good = 0; ext_supply = 0;
    wake_evt = 4'b0101; tick();
    check_mode(2'd2, "R9 wake ignored with no supply");
    ext_supply = 1; tick(); wake_evt = '0;
    check_mode(2'd3, "R9 wake accepted on external supply");
    tick(); check_mode(2'd0, "R9 back to run");
    ext_supply = 0;
    sw_idle_req = 1; tick(); sw_idle_req = 0;
    wake_evt = 4'b0001; tick(); wake_evt = '0;
    check_mode(2'd1, "R9 idle held with no supply");
    batt_good = 1;
    wake_evt = 4'b0001; tick(); wake_evt = '0;
    check_mode(2'd0, "R9 idle wakes once battery good");
  endtask

  task automatic t_forced();
    pwr_fail = 1; tick();
    check_mode(2'd2, "R10 power fail from run");
    wake_evt = 4'b0001; tick(); wake_evt = '0;
    check_mode(2'd2, "R10 wake blocked while power fail");
    pwr_fail = 0; go_run_from_stby();
    sw_idle_req = 1; tick(); sw_idle_req = 0;
    batt_swap = 1; tick();
    check_mode(2'd2, "R10 battery change from idle");
    batt_swap = 0; settle_cycles = 16'd5;
    wake_evt = 4'b0001; tick(); wake_evt = '0;
    check_mode(2'd3, "R10 restart before forced");
    pwr_fail = 1; tick(); pwr_fail = 0;
    check_mode(2'd2, "R10 power fail aborts restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_idle();
    t_stby_priority();
    t_req_blocked();
    t_restart_count();
    t_restart_ready();
    t_supply_gate();
    t_forced();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule